// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM whose data phase always trails its command phase by exactly one clock. Address and control are registered on a rising edge. The read or write that belongs to them takes place during the next cycle. Because every operation has the same one-cycle lag, a write can follow a read, or a read can follow a write, on consecutive clocks without an idle bus cycle. Read data leaves the storage array combinationally during the data cycle. There is no output register, so the outputs are flow-through.

Only three things start a new operation: the load/advance control, three chip enables, and a read/write select. If load/advance is held high after an operation, the block instead steps an internal two-bit burst counter. The burst visits four words in either linear or interleaved order. Clock enable freezes the whole block. Output enable gates the drive of the data outputs without waiting for the clock. The shared bidirectional bus is split into three signals: `din`, `dout` and `dout_en`. A pad or a test bench reconnects them.

Top module: `zbt_sram`

## Requirements
- R1: After a synchronous reset, `dout_en` stays low until a read has been loaded.
- R2: A read loaded at edge k (`adv_ld`=0, `rw`=1, chip selected) drives the word stored at its address on `dout`, with `dout_en` high, from just after edge k until the next enabled edge. No output register lies on that path.
- R3: A write loaded at edge k stores `din` at edge k+1, lane by lane. Lane i is bits [9i+8:9i]. It is written only when `bw_n[i]` was 0 at edge k. Lanes whose `bw_n` bit was 1 keep their old contents.
- R4: A read loaded on the edge right after a write to the same address returns the newly written data.
- R5: While `oe_n` is 1, `dout_en` is 0 at once, without waiting for a clock edge.
- R6: At any edge where `cen_n` is 1, every input except `rst` and `oe_n` is ignored. All internal state holds, no write takes place, and `dout`/`dout_en` keep their values.
- R7: A new operation is loaded only when `adv_ld`=0, `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other chip-enable combination with `adv_ld`=0 is a deselect, and `dout_en` is 0 in the cycle that follows.
- R8: A write that is waiting for its data cycle still completes at the edge where a deselect is sampled.
- R9: `dout_en` is 0 during the data cycle of every write.
- R10: With `adv_ld`=1 after a loaded operation, the same operation moves on to the next burst word. The burst count is n = 1, 2, 3, 0, ... and only the two low address bits change. They become (base+n) mod 4 when `burst_linear` was 1 at the load, and base XOR n when it was 0. The byte selects are sampled again on each advance.
- R11: With `adv_ld`=1 after a deselect, the block stays deselected and `dout_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| rw | input | 1 | 1 read, 0 write |
| bw_n | input | NB | Byte-lane write selects, active low |
| burst_linear | input | 1 | 1 linear burst order, 0 interleaved |
| addr | input | ADDR_W | Word address |
| din | input | NB*LANE_W | Write data for the pending data cycle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NB*LANE_W | Read data, flow-through |
| dout_en | output | 1 | Bus drive enable for `dout` |

## Verification
The checker relies on three properties of the inputs. Reset is synchronous. `oe_n` changes only between clock edges, so stability can be judged on sampled values. `din` has no effect outside a write's data cycle. The bench drives every input on the falling edge and samples five nanoseconds after the rising edge, so each sample falls inside one data cycle.

A behavioural model in the bench tracks the pending operation and the burst count. It keeps a reference array, and that array is fully written before any location is read. Stall cycles carry deliberately harmful inputs, such as a selected write to another address, so that an input which leaks through a stall shows up as corrupted data.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of burst word 'step' starting from 'base'
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       linear);
    return linear ? (base + step) : (base ^ step);
  endfunction

endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              sel,
  input  logic              adv_ld,
  input  logic              rw,
  input  logic [NB-1:0]     bw_n,
  input  logic              burst_linear,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [NB-1:0]     cur_bw_n
);

  op_e               op_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              lin_q;
  logic [NB-1:0]     bw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b1;
      bw_q   <= '1;
    end else if (!cen_n) begin
      bw_q <= bw_n;
      if (!adv_ld) begin
        if (sel) begin
          op_q   <= rw ? OP_READ : OP_WRITE;
          base_q <= addr;
          cnt_q  <= '0;
          lin_q  <= burst_linear;
        end else begin
          op_q <= OP_IDLE;
        end
      end else if (op_q != OP_IDLE) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign op       = op_q;
  assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, lin_q)};
  assign cur_bw_n = bw_q;

endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int NB     = 2
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [NB-1:0]        lane_en,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [NB*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]    raddr,
  output logic [NB*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_en[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int NB     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cen_n,
  input  logic                 ce1_n,
  input  logic                 ce2,
  input  logic                 ce3_n,
  input  logic                 adv_ld,
  input  logic                 rw,
  input  logic [NB-1:0]        bw_n,
  input  logic                 burst_linear,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NB*LANE_W-1:0] din,
  input  logic                 oe_n,
  output logic [NB*LANE_W-1:0] dout,
  output logic                 dout_en
);

  localparam int DATA_W = NB * LANE_W;

  op_e               op;
  logic [ADDR_W-1:0] cur_addr;
  logic [NB-1:0]     cur_bw_n;
  logic              sel;
  logic              we;
  logic [DATA_W-1:0] rdata;

  assign sel = !ce1_n && ce2 && !ce3_n;

  zbt_ctrl #(.ADDR_W(ADDR_W), .NB(NB)) ctrl_i (
    .clk, .rst, .cen_n, .sel, .adv_ld, .rw, .bw_n, .burst_linear, .addr,
    .op, .cur_addr, .cur_bw_n
  );

  // data cycle of a write closes on the next enabled edge
  assign we = !cen_n && (op == OP_WRITE);

  zbt_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NB(NB)) array_i (
    .clk, .we, .lane_en(~cur_bw_n), .waddr(cur_addr), .wdata(din),
    .raddr(cur_addr), .rdata
  );

  assign dout    = rdata;
  assign dout_en = (op == OP_READ) && !oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cen_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              adv_ld,
  input logic              rw,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);

  logic sel_s;
  assign sel_s = !ce1_n && ce2 && !ce3_n;

  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cen_n) && $stable(oe_n)) |-> ($stable(dout) && $stable(dout_en)));

  // R7
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!cen_n && !adv_ld && !sel_s)) |-> !dout_en);

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!cen_n && !adv_ld && sel_s && !rw)) |-> !dout_en);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!cen_n && !adv_ld && sel_s && rw) && !oe_n) |-> dout_en);

endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adv_ld(adv_ld), .rw(rw), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
);

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int NB = 2;
  localparam int DW = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          cen_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic          adv_ld = 1'b0, rw = 1'b1, burst_linear = 1'b1, oe_n = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  zbt_sram #(.ADDR_W(AW), .LANE_W(LW), .NB(NB)) dut_i (
    .clk, .rst, .cen_n, .ce1_n, .ce2, .ce3_n, .adv_ld, .rw, .bw_n,
    .burst_linear, .addr, .din, .oe_n, .dout, .dout_en
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  int            m_op = 0;            // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_lin = 1'b1;
  logic [NB-1:0] m_bw = '1;
  logic [DW-1:0] dctr = 18'h00001;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string tag);
    logic exp_en;
    exp_en = (m_op == 1) && !oe_n;
    checks++;
    if (dout_en !== exp_en) begin
      errors++;
      $display("FAIL %s: dout_en actual=%0b expected=%0b", tag, dout_en, exp_en);
    end
    if (exp_en) begin
      checks++;
      if (dout !== ref_mem[m_addr()]) begin
        errors++;
        $display("FAIL %s: dout actual=%h expected=%h (addr %h)", tag, dout,
                 ref_mem[m_addr()], m_addr());
      end
    end
  endtask

  task automatic step(input string tag, input logic s_cen, input logic s_c1,
                      input logic s_c2, input logic s_c3, input logic s_adv,
                      input logic s_rw, input logic [NB-1:0] s_bw,
                      input logic [AW-1:0] s_a, input logic s_lin, input logic s_oe);
    logic sel;
    @(negedge clk);
    cen_n = s_cen; ce1_n = s_c1; ce2 = s_c2; ce3_n = s_c3; adv_ld = s_adv;
    rw = s_rw; bw_n = s_bw; addr = s_a; burst_linear = s_lin; oe_n = s_oe;
    dctr = dctr * 18'd5 + 18'h137;
    din = dctr;
    @(posedge clk);
    sel = !s_c1 && s_c2 && !s_c3;
    if (!s_cen) begin
      if (m_op == 2)
        for (int l = 0; l < NB; l++)
          if (!m_bw[l]) ref_mem[m_addr()][l*LW +: LW] = din[l*LW +: LW];
      m_bw = s_bw;
      if (!s_adv) begin
        if (sel) begin
          m_op = s_rw ? 1 : 2; m_base = s_a; m_cnt = '0; m_lin = s_lin;
        end else m_op = 0;
      end else if (m_op != 0) m_cnt = m_cnt + 2'd1;
    end
    #5;
    check(tag);
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    step(tag, 0, 0, 1, 0, 0, 1, '1, a, 1, 0);
  endtask
  task automatic rd_oe(input string tag, input logic [AW-1:0] a, input logic oe);
    step(tag, 0, 0, 1, 0, 0, 1, '1, a, 1, oe);
  endtask
  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [NB-1:0] bw);
    step(tag, 0, 0, 1, 0, 0, 0, bw, a, 1, 0);
  endtask
  task automatic load(input string tag, input logic [AW-1:0] a, input logic r, input logic lin);
    step(tag, 0, 0, 1, 0, 0, r, '0, a, lin, 0);
  endtask
  task automatic advc(input string tag);
    // selects deliberately off and address junk: advance must ignore them
    step(tag, 0, 1, 0, 1, 1, 0, '0, 8'hA5, 0, 0);
  endtask
  task automatic desel(input string tag, input logic c1, input logic c2, input logic c3);
    step(tag, 0, c1, c2, c3, 0, 1, '1, 8'h00, 1, 0);
  endtask
  task automatic stall(input string tag);
    // a selected write load with full byte enables: must be ignored
    step(tag, 1, 0, 1, 0, 0, 0, '0, 8'h77, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset
    #1;
    checks++;
    if (dout_en !== 1'b0) begin
      errors++;
      $display("FAIL R1: dout_en actual=%0b expected=0", dout_en);
    end
    desel("R1", 1, 1, 1);

    // fill every address with back-to-back writes (R9 during data cycles)
    for (int a = 0; a < DEPTH; a++) wr("R9", a[AW-1:0], '0);
    desel("R8", 1, 0, 1);
    // read everything, check async oe gating inside each data cycle
    for (int a = 0; a < DEPTH; a++) begin
      rd("R2", a[AW-1:0]);
      oe_n = 1'b1; #1;
      checks++;
      if (dout_en !== 1'b0) begin
        errors++;
        $display("FAIL R5: dout_en actual=%0b expected=0", dout_en);
      end
      oe_n = 1'b0; #1;
    end

    // write followed at once by read of the same word, then read->write
    for (int a = 0; a < DEPTH; a += 3) begin
      wr("R9", a[AW-1:0], '0);
      rd("R4", a[AW-1:0]);
    end

    // byte masks, every combination
    for (int a = 32; a < 48; a++)
      for (int m = 0; m < 4; m++) begin
        wr("R3", a[AW-1:0], m[NB-1:0]);
        rd("R3", a[AW-1:0]);
      end

    // oe held high during reads
    for (int a = 0; a < 8; a++) rd_oe("R5", a[AW-1:0], 1'b1);

    // stalls with pending write and pending read
    wr("R9", 8'h10, '0);
    stall("R6"); stall("R6"); stall("R6");
    rd("R6", 8'h10);
    stall("R6"); stall("R6");
    rd("R6", 8'h77);
    rd("R6", 8'h11);

    // deselect through each chip enable, with a pending write
    wr("R9", 8'h20, '0); desel("R8", 1, 1, 0); rd("R8", 8'h20);
    wr("R9", 8'h21, '0); desel("R8", 0, 0, 0); rd("R8", 8'h21);
    wr("R9", 8'h22, '0); desel("R8", 0, 1, 1); rd("R8", 8'h22);
    rd("R2", 8'h23); desel("R7", 1, 1, 0);
    rd("R2", 8'h24); desel("R7", 0, 0, 0);
    rd("R2", 8'h25); desel("R7", 0, 1, 1);

    // bursts: every start offset, both orders, with a wrap
    for (int lin = 0; lin < 2; lin++)
      for (int b = 0; b < 4; b++) begin
        logic [AW-1:0] base;
        base = 8'h80 + 8'(lin * 16) + 8'(b);
        load("R10", base, 1'b0, lin[0]);
        advc("R10"); advc("R10"); advc("R10");
        desel("R10", 1, 0, 1);
        load("R10", base, 1'b1, lin[0]);
        advc("R10"); advc("R10"); advc("R10"); advc("R10");
        // single reads of the whole aligned group confirm where data went
        for (int k = 0; k < 4; k++) rd("R10", {base[AW-1:2], k[1:0]});
      end

    // burst write with a stall in the middle
    load("R6", 8'hC1, 1'b0, 1'b0);
    advc("R6"); stall("R6"); stall("R6"); advc("R6"); advc("R6");
    desel("R6", 1, 0, 1);
    for (int k = 0; k < 4; k++) rd("R6", {6'h30, k[1:0]});

    // advance after deselect stays idle
    desel("R11", 1, 0, 1);
    advc("R11"); advc("R11"); advc("R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule